// File: doc/BRIEF.md
# Transmit descriptor ring fetch engine

This block is the transmit half of a descriptor-ring DMA. Software writes 12-byte descriptors into a local descriptor memory and then moves a free-running 16-bit producer index forward. Whenever both enable bits are set and the producer index differs from the engine's own 16-bit consumer index, the engine does three things in order. It reads the descriptor in the slot the consumer index selects, as three 32-bit words. It hands the frame's buffer address, length and per-frame flags to a downstream packet mover through a valid/ready request. It waits for the mover's done pulse and then advances the consumer index by one.

The descriptor memory is outside the block. The engine reaches it through a read port with one cycle of latency and a one-word write port. It uses the write port for one purpose only: when the mover reports that it ran dry partway through a frame, the engine sets the underrun flag in that descriptor's first word. If a descriptor lacks the start flag and arrives while no frame is open, the engine drops it without a request and still advances the consumer index. Descriptors in the middle of an open frame are passed on whatever their start flag says.

Top module: `tx_ring_fetch`

## Requirements
- R1: After reset the control register, producer index and consumer index read 0, and req_valid, desc_rd_en and desc_wr_en are low.
- R2: A descriptor fetch starts only when control bit 0 (DMA enable) and control bit 1 (ring enable) are both 1 and the producer index differs from the consumer index. With only one of the two bits set, nothing is fetched.
- R3: The descriptor for consumer index c is read from word addresses 3*s, 3*s+1 and 3*s+2, where s = c mod 256. Read addresses never exceed 767, and the slot after 255 is slot 0.
- R4: The request carries these fields. req_len is word0[27:16]. req_addr is {word2, word1}. req_sop is word0[13], req_eop is word0[14], req_crc is word0[6] and req_qtag is word0[12:7].
- R5: After req_valid rises, it stays high with every request field stable until a cycle in which req_ready is high. It is low in the cycle that follows that one.
- R6: The consumer index rises by exactly 1, modulo 2^16, for each descriptor finished. It never moves while it already equals the producer index, and it stops once it reaches the producer index.
- R7: When done_underrun comes with done_valid, the engine writes the descriptor's word0 with bit 9 set back to word address 3*s before it advances the consumer index. No write happens otherwise.
- R8: If no frame is open (reset, or the last forwarded descriptor had bit 14 set) and a descriptor lacks bit 13, the engine issues no request for it and advances the consumer index. A descriptor that follows a forwarded descriptor without bit 14 is forwarded whatever its bit 13 says.
- R9: Clearing the enables while a descriptor is in flight lets that descriptor finish and advance the index. No further fetch starts until both bits are set again.
- R10: The register map is as follows. Address 0 holds the control bits [1:0] and is read/write. Address 1 holds the producer index [15:0] and is read/write. Address 2 holds the consumer index and is read-only: a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| desc_rd_en | output | 1 | Descriptor memory read enable |
| desc_rd_addr | output | AW (10) | Descriptor memory word address for reads |
| desc_rd_data | input | 32 | Read data, valid one cycle after desc_rd_en |
| desc_wr_en | output | 1 | Descriptor memory write enable (underrun write-back) |
| desc_wr_addr | output | AW (10) | Descriptor memory word address for writes |
| desc_wr_data | output | 32 | Descriptor memory write data |
| req_valid | output | 1 | Frame request to the packet mover |
| req_ready | input | 1 | Mover accepts the request |
| req_addr | output | 64 | Buffer address |
| req_len | output | LEN_W (12) | Buffer length in bytes |
| req_sop | output | 1 | Start-of-frame flag |
| req_eop | output | 1 | End-of-frame flag |
| req_crc | output | 1 | Append-CRC flag |
| req_qtag | output | QTAG_W (6) | Queue tag |
| done_valid | input | 1 | Mover has finished the accepted request |
| done_underrun | input | 1 | Mover ran dry partway through the frame (with done_valid) |

## Verification
The properties take three things for granted. Software moves the producer index forward only, never more than 256 entries past the consumer index, and never back onto a consumer index whose fetch is already under way. The mover raises done_valid only after it has accepted a request, and it does so once per request. The stimulus respects all three: it writes only increasing producer values in batches of at most 256 descriptors, and its mover model does one fixed sequence per request: ready after a delay, then a single done pulse after another delay. Within those limits the bench covers each enable combination, frames that span several descriptors, skipped descriptors, an underrun write-back, a full lap of the ring past slot 255, and a disable that lands while a request is waiting.

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch #(
  parameter int IDX_W     = 16,
  parameter int RING_LOG2 = 8,
  parameter int LEN_W     = 12,
  parameter int QTAG_W    = 6,
  localparam int AW       = $clog2((1 << RING_LOG2) * 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              desc_rd_en,
  output logic [AW-1:0]     desc_rd_addr,
  input  logic [31:0]       desc_rd_data,
  output logic              desc_wr_en,
  output logic [AW-1:0]     desc_wr_addr,
  output logic [31:0]       desc_wr_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              req_sop,
  output logic              req_eop,
  output logic              req_crc,
  output logic [QTAG_W-1:0] req_qtag,
  input  logic              done_valid,
  input  logic              done_underrun
);
  localparam int RING     = 1 << RING_LOG2;
  localparam int WORDS    = RING * 3;
  localparam int LEN_LSB  = 16;
  localparam int QTAG_LSB = 7;
  localparam int CRC_BIT  = 6;
  localparam int UNDR_BIT = 9;
  localparam int SOP_BIT  = 13;
  localparam int EOP_BIT  = 14;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_CAP, S_REQ, S_WAIT, S_WB
  } state_t;

  state_t             state;
  logic [1:0]         ctrl_q;
  logic [IDX_W-1:0]   prod_q;
  logic [IDX_W-1:0]   cons_q;
  logic               in_frame_q;
  logic [31:0]        w0_q, w1_q, w2_q;

  logic [RING_LOG2-1:0] slot;
  logic [AW-1:0]        base;
  logic [1:0]           word_off;
  logic                 fetch_ok;
  logic                 skip;
  logic                 unused_wdata;

  assign slot     = cons_q[RING_LOG2-1:0];
  assign base     = AW'({slot, 1'b0}) + AW'(slot);
  assign fetch_ok = (ctrl_q == 2'b11) && (prod_q != cons_q);
  assign skip     = !in_frame_q && !w0_q[SOP_BIT];
  assign word_off = (state == S_RD1) ? 2'd1 : (state == S_RD2) ? 2'd2 : 2'd0;

  assign desc_rd_en   = (state == S_RD0) || (state == S_RD1) || (state == S_RD2);
  assign desc_rd_addr = base + AW'(word_off);
  assign desc_wr_en   = (state == S_WB);
  assign desc_wr_addr = base;
  assign desc_wr_data = w0_q | (32'd1 << UNDR_BIT);

  assign req_valid = (state == S_REQ);
  assign req_addr  = {w2_q, w1_q};
  assign req_len   = w0_q[LEN_LSB +: LEN_W];
  assign req_sop   = w0_q[SOP_BIT];
  assign req_eop   = w0_q[EOP_BIT];
  assign req_crc   = w0_q[CRC_BIT];
  assign req_qtag  = w0_q[QTAG_LSB +: QTAG_W];

  assign unused_wdata = ^reg_wdata[31:IDX_W];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, ctrl_q};
      2'd1:    reg_rdata = {{(32-IDX_W){1'b0}}, prod_q};
      2'd2:    reg_rdata = {{(32-IDX_W){1'b0}}, cons_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ctrl_q     <= '0;
      prod_q     <= '0;
      cons_q     <= '0;
      in_frame_q <= 1'b0;
      w0_q       <= '0;
      w1_q       <= '0;
      w2_q       <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    ctrl_q <= reg_wdata[1:0];
          2'd1:    prod_q <= reg_wdata[IDX_W-1:0];
          default: ;
        endcase
      end
      case (state)
        S_IDLE: if (fetch_ok) state <= S_RD0;
        S_RD0:  state <= S_RD1;
        S_RD1: begin
          w0_q  <= desc_rd_data;
          state <= S_RD2;
        end
        S_RD2: begin
          w1_q  <= desc_rd_data;
          state <= S_CAP;
        end
        S_CAP: begin
          w2_q <= desc_rd_data;
          if (skip) begin
            cons_q <= cons_q + IDX_W'(1);
            state  <= S_IDLE;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: if (req_ready) state <= S_WAIT;
        S_WAIT: if (done_valid) begin
          in_frame_q <= !w0_q[EOP_BIT];
          if (done_underrun) begin
            state <= S_WB;
          end else begin
            cons_q <= cons_q + IDX_W'(1);
            state  <= S_IDLE;
          end
        end
        S_WB: begin
          cons_q <= cons_q + IDX_W'(1);
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_fetch_chk.sv
module tx_ring_fetch_chk #(
  parameter int IDX_W  = 16,
  parameter int AW     = 10,
  parameter int WORDS  = 768,
  parameter int LEN_W  = 12,
  parameter int QTAG_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctrl_q,
  input logic [IDX_W-1:0]  prod_q,
  input logic [IDX_W-1:0]  cons_q,
  input logic              desc_rd_en,
  input logic [AW-1:0]     desc_rd_addr,
  input logic              desc_wr_en,
  input logic [31:0]       desc_wr_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic [63:0]       req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_sop,
  input logic              req_eop,
  input logic              req_crc,
  input logic [QTAG_W-1:0] req_qtag
);
  p_fetch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_rd_en) |-> ($past(ctrl_q) == 2'b11) && ($past(prod_q) != $past(cons_q)));

  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_en |-> (int'(desc_rd_addr) < WORDS));

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_rd_en, desc_wr_en, req_valid}));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_len)
      && $stable(req_sop) && $stable(req_eop) && $stable(req_crc) && $stable(req_qtag));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  p_cons_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_q != $past(cons_q)) |-> (cons_q == IDX_W'($past(cons_q) + IDX_W'(1))));

  p_cons_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_q != $past(cons_q)) |-> ($past(cons_q) != $past(prod_q)));

  p_cons_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $stable(cons_q));

  p_wb_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> desc_wr_data[9]);
endmodule

bind tx_ring_fetch tx_ring_fetch_chk #(
  .IDX_W(IDX_W), .AW(AW), .WORDS(WORDS), .LEN_W(LEN_W), .QTAG_W(QTAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .prod_q(prod_q), .cons_q(cons_q),
  .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
  .desc_wr_en(desc_wr_en), .desc_wr_data(desc_wr_data),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
  .req_sop(req_sop), .req_eop(req_eop), .req_crc(req_crc), .req_qtag(req_qtag)
);

// File: tb/tx_ring_fetch_tb.sv
module tx_ring_fetch_tb;
  localparam int WORDS = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        desc_rd_en;
  logic [9:0]  desc_rd_addr;
  logic [31:0] desc_rd_data = 32'd0;
  logic        desc_wr_en;
  logic [9:0]  desc_wr_addr;
  logic [31:0] desc_wr_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [63:0] req_addr;
  logic [11:0] req_len;
  logic        req_sop, req_eop, req_crc;
  logic [5:0]  req_qtag;
  logic        done_valid = 1'b0;
  logic        done_underrun = 1'b0;

  logic [31:0] mem [WORDS];

  int vectors = 0;
  int errors  = 0;

  tx_ring_fetch u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .desc_wr_en(desc_wr_en), .desc_wr_addr(desc_wr_addr), .desc_wr_data(desc_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_sop(req_sop), .req_eop(req_eop), .req_crc(req_crc), .req_qtag(req_qtag),
    .done_valid(done_valid), .done_underrun(done_underrun)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (desc_rd_en) desc_rd_data <= mem[desc_rd_addr];
    if (desc_wr_en) mem[desc_wr_addr] <= desc_wr_data;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(int len, bit sop, bit eop, bit crc, int qtag);
    return (32'(len) << 16) | (32'(eop) << 14) | (32'(sop) << 13)
         | (32'(qtag & 63) << 7) | (32'(crc) << 6);
  endfunction

  task automatic put(int s, logic [31:0] w0, logic [31:0] lo, logic [31:0] hi);
    mem[3*s]   <= w0;
    mem[3*s+1] <= lo;
    mem[3*s+2] <= hi;
  endtask

  // reference model state
  logic [15:0] mdl_prod = 16'd0;
  logic [15:0] mdl_cons = 16'd0;
  bit          mdl_in_frame = 1'b0;
  logic [15:0] uflag_cons = 16'd0;
  bit          uflag_on = 1'b0;
  int          extra_delay = 0;
  int          nreq = 0;
  int          nwb = 0;
  bit          rd_seen = 1'b0;
  bit          seen_top = 1'b0;
  bit          wb_pend = 1'b0;
  logic [9:0]  wb_addr_exp = '0;
  logic [31:0] wb_data_exp = '0;
  logic [31:0] e0, e1, e2;
  int          ms = 0;
  int          cnt = 0;

  function automatic int slot_base(logic [15:0] c);
    return 3 * int'(c[7:0]);
  endfunction

  // mover model and per-clock comparison
  initial begin : mover
    forever begin
      @(negedge clk);
      req_ready = 1'b0;
      done_valid = 1'b0;
      done_underrun = 1'b0;
      if (rst_n) begin
        if (desc_rd_en) rd_seen = 1'b1;
        if (desc_rd_en && desc_rd_addr == 10'd767) seen_top = 1'b1;
        chk("R7", "write-back enable", desc_wr_en, wb_pend);
        if (wb_pend && desc_wr_en) begin
          chk("R7", "write-back address", desc_wr_addr, wb_addr_exp);
          chk("R7", "write-back data", desc_wr_data, wb_data_exp);
          nwb++;
        end
        wb_pend = 1'b0;
        case (ms)
          0: if (req_valid) begin
            while (mdl_cons != mdl_prod && !mdl_in_frame && !mem[slot_base(mdl_cons)][13])
              mdl_cons = mdl_cons + 16'd1;
            chk("R6", "request with work pending", mdl_cons != mdl_prod, 1);
            e0 = mem[slot_base(mdl_cons)];
            e1 = mem[slot_base(mdl_cons) + 1];
            e2 = mem[slot_base(mdl_cons) + 2];
            chk("R4", "length", req_len, e0[27:16]);
            chk("R4", "address", req_addr, {e2, e1});
            chk("R4", "sop", req_sop, e0[13]);
            chk("R4", "eop", req_eop, e0[14]);
            chk("R4", "crc", req_crc, e0[6]);
            chk("R4", "qtag", req_qtag, e0[12:7]);
            cnt = (nreq % 3) + extra_delay;
            nreq++;
            ms = 1;
          end
          1: begin
            chk("R5", "valid held", req_valid, 1);
            chk("R5", "address held", req_addr, {e2, e1});
            chk("R5", "length held", req_len, e0[27:16]);
          end
          2: begin
            chk("R5", "valid dropped after accept", req_valid, 0);
            cnt = nreq % 2;
            ms = 3;
          end
          default: begin
            chk("R5", "no request while busy", req_valid, 0);
            if (cnt == 0) begin
              done_valid = 1'b1;
              done_underrun = uflag_on && (mdl_cons == uflag_cons);
              if (done_underrun) begin
                wb_pend = 1'b1;
                wb_addr_exp = 10'(slot_base(mdl_cons));
                wb_data_exp = e0 | 32'h200;
              end
              mdl_in_frame = !e0[14];
              mdl_cons = mdl_cons + 16'd1;
              ms = 0;
            end else cnt--;
          end
        endcase
        if (ms == 1) begin
          if (cnt == 0) begin
            req_ready = 1'b1;
            ms = 2;
          end else cnt--;
        end
      end
    end
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd1) mdl_prod = d[15:0];
  endtask

  task automatic reg_check(string req, string what, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, what, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    vectors++;
    errors++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", nreq, -1);
    finish_run();
  end

  initial begin : main
    for (int i = 0; i < WORDS; i++) mem[i] <= 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_valid", req_valid, 0);
    chk("R1", "desc_rd_en", desc_rd_en, 0);
    chk("R1", "desc_wr_en", desc_wr_en, 0);
    reg_check("R1", "ctrl", 2'd0, 0);
    reg_check("R1", "producer", 2'd1, 0);
    reg_check("R1", "consumer", 2'd2, 0);

    // R2: four single-descriptor frames, gated by the enables
    put(0, mk_w0(60, 1, 1, 1, 5), 32'h1000_0000, 32'h0000_0001);
    put(1, mk_w0(1514, 1, 1, 0, 63), 32'h2000_0040, 32'hdead_0002);
    put(2, mk_w0(4095, 1, 1, 1, 0), 32'hffff_fff0, 32'hffff_ffff);
    put(3, mk_w0(1, 1, 1, 0, 42), 32'h0000_0002, 32'h0);
    rd_seen = 1'b0;
    reg_write(2'd1, 32'd4);
    repeat (20) @(negedge clk);
    chk("R2", "fetch with both enables off", rd_seen, 0);
    reg_write(2'd0, 32'd1);
    repeat (20) @(negedge clk);
    chk("R2", "fetch with ring enable off", rd_seen, 0);
    reg_write(2'd0, 32'd2);
    repeat (20) @(negedge clk);
    chk("R2", "fetch with DMA enable off", rd_seen, 0);
    reg_check("R2", "consumer while gated", 2'd2, 0);
    reg_write(2'd0, 32'd3);
    repeat (100) @(negedge clk);
    reg_check("R6", "consumer after four frames", 2'd2, 4);
    chk("R6", "request count", nreq, 4);

    // R8: multi-descriptor frame, a stray descriptor, then a normal frame
    put(4, mk_w0(100, 1, 0, 1, 1), 32'h4000, 32'h4);
    put(5, mk_w0(200, 0, 0, 0, 2), 32'h5000, 32'h5);
    put(6, mk_w0(300, 0, 1, 0, 3), 32'h6000, 32'h6);
    put(7, mk_w0(400, 0, 1, 1, 4), 32'h7000, 32'h7);
    put(8, mk_w0(500, 1, 1, 1, 9), 32'h8000, 32'h8);
    reg_write(2'd1, 32'd9);
    repeat (120) @(negedge clk);
    reg_check("R8", "consumer past skipped descriptor", 2'd2, 9);
    chk("R8", "requests (mid-frame forwarded, stray skipped)", nreq, 8);

    // R7: underrun write-back
    put(9, mk_w0(700, 1, 1, 0, 7), 32'h9000, 32'h9);
    uflag_cons = 16'd9;
    uflag_on = 1'b1;
    reg_write(2'd1, 32'd10);
    repeat (60) @(negedge clk);
    uflag_on = 1'b0;
    reg_check("R7", "consumer after underrun", 2'd2, 10);
    chk("R7", "descriptor word0 in memory", mem[27], mk_w0(700, 1, 1, 0, 7) | 32'h200);
    chk("R7", "write-back count", nwb, 1);

    // R3: a full lap of the ring
    for (int s = 10; s < 256; s++)
      put(s, mk_w0(s * 7 + 64, 1, 1, s % 2, s % 64), {24'h0, 8'(s)} << 4, ~{24'h0, 8'(s)});
    reg_write(2'd1, 32'd200);
    repeat (3000) @(negedge clk);
    reg_check("R6", "consumer at 200", 2'd2, 200);
    reg_write(2'd1, 32'd266);
    repeat (1200) @(negedge clk);
    reg_check("R3", "consumer after ring wrap", 2'd2, 266);
    chk("R3", "top word of ring read", seen_top, 1);
    chk("R7", "no extra write-back", nwb, 1);

    // R9: disable while a request is waiting
    extra_delay = 15;
    reg_write(2'd1, 32'd269);
    do @(negedge clk); while (!req_valid);
    reg_write(2'd0, 32'd0);
    rd_seen = 1'b0;
    repeat (100) @(negedge clk);
    reg_check("R9", "in-flight descriptor finished", 2'd2, 267);
    chk("R9", "no fetch after disable", rd_seen, 0);
    extra_delay = 0;
    reg_write(2'd0, 32'd3);
    repeat (100) @(negedge clk);
    reg_check("R9", "resumed after re-enable", 2'd2, 269);

    // R10: register map
    reg_write(2'd2, 32'h1234);
    @(negedge clk);
    reg_check("R10", "consumer ignores writes", 2'd2, 269);
    reg_check("R10", "producer readback", 2'd1, 269);
    reg_check("R10", "control readback", 2'd0, 3);
    finish_run();
  end
endmodule